// File: doc/BRIEF.md
# Spike Batching Transmit Packetizer

This block assembles 512-bit words for a host-bound transmit FIFO. While a run is in progress it drains a queue of spiking-neuron addresses. It turns each address into a 32-bit entry stamped with the low byte of the current step count. It gathers fourteen entries into one packet, which carries a 32-bit tag and the full step count. When the run finishes, any partly filled batch is flushed.

When no run is in progress, the block forwards read responses from two other queues, each in its own packet with a fixed 16-bit tag: 256-bit memory words and 53-bit neuron records. Memory responses take priority. A source queue is popped only when it holds data, and the transmit FIFO is written only while it has room. A stalled packet is held unchanged until it can be written.

Top module: `spk_tx_packer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `tx_state` is 0 and `tx_wr`, `spk_rd`, `mem_rd` and `nrn_rd` are all low.
- R2: A spike entry is 32 bits. It holds `step_count[7:0]` (sampled in the cycle the address is read) in bits 31:24, a 1 in bit 23, zeros in bits 22:16 and `spk_addr[15:0]` in bits 15:0. Address bit 16 is dropped.
- R3: A spike packet holds 0xEEEEEEEE in bits 511:480 and `step_count` in bits 31:0. Slot s (s = 0..13) occupies bits 32+32s+31 : 32+32s. The first spike read in a full batch lands in slot 0 and the last in slot 13.
- R4: When fourteen entries are held, the block goes to state 3 and writes the packet. It then clears the batch and returns to state 2.
- R5: When `run_done` is high, the spike queue is empty and k entries (0 < k < 14) are pending, the packet is sent with the entries in slots 14-k..13 in read order and zeros in slots below.
- R6: When `run_done` is high in state 2 with the spike queue empty and no entry pending, the block returns to state 1 without writing.
- R7: A memory response packet holds 0xBBBB in bits 511:496, zeros in bits 495:256 and `mem_data` in bits 255:0. `mem_rd` pops the word in the same cycle as the write.
- R8: A neuron response packet holds 0xCCCC in bits 511:496, zeros in bits 495:53 and `nrn_data` in bits 52:0. `nrn_rd` pops the record in the same cycle as the write.
- R9: In state 1, with both response queues non-empty, the memory response is sent first.
- R10: `tx_wr` is never high while `tx_full` is high. A spike packet stalled by `tx_full` stays in state 3 with unchanged contents, and is written once `tx_full` falls.
- R11: Each read strobe is high only while its queue's empty flag is low, and at most one strobe is high per cycle.
- R12: When `run_active` is high in state 1, the block moves to state 2 and forwards no response. Responses queued during a run are sent only after the block is back in state 1.
- R13: `tx_state` encodes reset = 0, idle = 1, collecting = 2 and sending = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_active | input | 1 | Run in progress |
| run_done | input | 1 | Run finished (level) |
| step_count | input | 32 | Current step counter |
| spk_empty | input | 1 | Spike queue empty |
| spk_addr | input | 17 | Head of spike queue (shown ahead of the read) |
| spk_rd | output | 1 | Spike queue pop |
| mem_empty | input | 1 | Memory response queue empty |
| mem_data | input | 256 | Head memory response |
| mem_rd | output | 1 | Memory response pop |
| nrn_empty | input | 1 | Neuron response queue empty |
| nrn_data | input | 53 | Head neuron response |
| nrn_rd | output | 1 | Neuron response pop |
| tx_full | input | 1 | Transmit FIFO full |
| tx_data | output | 512 | Transmit word |
| tx_wr | output | 1 | Transmit write |
| tx_state | output | 2 | Current controller state |

## Verification
Responses are queued while the transmit FIFO is full and then released. This separates the memory-before-neuron ordering, the two response layouts and the full-flag gating. One run fills a whole batch of fourteen addresses whose bit 16 is set, with the send stalled for several cycles. This exposes slot order, the dropped address bit, the stall hold and the batch clear. A second batch of two spikes at a new step value is flushed by the run end. A memory response queued during that run must come out only after the flush, which covers partial-slot placement and the rule that responses wait for the run to end. A final run that ends with no spikes must produce no write.

// File: rtl/spk_tx_pkg.sv
package spk_tx_pkg;

    localparam int PKT_W    = 512;
    localparam int ENTRY_W  = 32;
    localparam int BATCH_N  = 14;
    localparam int STEP_W   = 32;
    localparam int NADDR_W  = 17;
    localparam int MEM_W    = 256;
    localparam int NRN_W    = 53;
    localparam int TAG16_W  = 16;
    localparam int SR_W     = BATCH_N * ENTRY_W;
    localparam int CNT_W    = $clog2(BATCH_N + 1);

    localparam logic [31:0]        SPIKE_TAG = 32'hEEEE_EEEE;
    localparam logic [TAG16_W-1:0] MEM_TAG   = 16'hBBBB;
    localparam logic [TAG16_W-1:0] NRN_TAG   = 16'hCCCC;

    // encoding is visible on tx_state, values fixed
    typedef enum logic [1:0] {
        ST_RESET   = 2'd0,
        ST_IDLE    = 2'd1,
        ST_COLLECT = 2'd2,
        ST_SEND    = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_MEM   = 2'd1,
        SEL_NRN   = 2'd2,
        SEL_SPIKE = 2'd3
    } frame_sel_e;

    typedef struct packed {
        logic [7:0]  stamp;
        logic        mark;
        logic [6:0]  pad;
        logic [15:0] addr;
    } spike_entry_t;

    function automatic spike_entry_t make_entry(input logic [7:0] stamp,
                                                input logic [15:0] addr);
        spike_entry_t e;
        e.stamp = stamp;
        e.mark  = 1'b1;
        e.pad   = '0;
        e.addr  = addr;
        return e;
    endfunction

    function automatic logic [PKT_W-1:0] frame_mem(input logic [MEM_W-1:0] d);
        return {MEM_TAG, {(PKT_W - TAG16_W - MEM_W){1'b0}}, d};
    endfunction

    function automatic logic [PKT_W-1:0] frame_nrn(input logic [NRN_W-1:0] d);
        return {NRN_TAG, {(PKT_W - TAG16_W - NRN_W){1'b0}}, d};
    endfunction

    function automatic logic [PKT_W-1:0] frame_spike(input logic [SR_W-1:0] sr,
                                                     input logic [STEP_W-1:0] step);
        return {SPIKE_TAG, sr, step};
    endfunction

endpackage

// File: rtl/spk_batch_acc.sv
module spk_batch_acc
    import spk_tx_pkg::*;
#(
    parameter int DEPTH = BATCH_N,
    parameter int EW    = ENTRY_W,
    localparam int AW   = EW * DEPTH,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          clear,
    input  logic [EW-1:0] entry,
    output logic [AW-1:0] acc,
    output logic [CW-1:0] count
);

    // newest entry enters at the top, oldest drifts toward slot 0
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc   <= '0;
            count <= '0;
        end else if (push) begin
            acc   <= {entry, acc[AW-1:EW]};
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/spk_tx_ctrl.sv
module spk_tx_ctrl
    import spk_tx_pkg::*;
#(
    parameter int DEPTH = BATCH_N,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_active,
    input  logic          run_done,
    input  logic          spk_empty,
    input  logic          mem_empty,
    input  logic          nrn_empty,
    input  logic          tx_full,
    input  logic [CW-1:0] count,
    output tx_state_e     state,
    output frame_sel_e    sel,
    output logic          spk_rd,
    output logic          mem_rd,
    output logic          nrn_rd,
    output logic          tx_wr,
    output logic          push,
    output logic          clear
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    tx_state_e nxt;

    always_comb begin
        nxt    = state;
        sel    = SEL_NONE;
        spk_rd = 1'b0;
        mem_rd = 1'b0;
        nrn_rd = 1'b0;
        tx_wr  = 1'b0;
        push   = 1'b0;
        clear  = 1'b0;
        unique case (state)
            ST_RESET: nxt = ST_IDLE;
            ST_IDLE: begin
                if (run_active) begin
                    nxt = ST_COLLECT;
                end else if (!tx_full) begin
                    if (!mem_empty) begin
                        sel    = SEL_MEM;
                        mem_rd = 1'b1;
                        tx_wr  = 1'b1;
                    end else if (!nrn_empty) begin
                        sel    = SEL_NRN;
                        nrn_rd = 1'b1;
                        tx_wr  = 1'b1;
                    end
                end
            end
            ST_COLLECT: begin
                if (count == FULL_CNT) begin
                    nxt = ST_SEND;
                end else if (!spk_empty) begin
                    spk_rd = 1'b1;
                    push   = 1'b1;
                end else if (run_done) begin
                    nxt = (count != '0) ? ST_SEND : ST_IDLE;
                end
            end
            ST_SEND: begin
                sel = SEL_SPIKE;
                if (!tx_full) begin
                    tx_wr = 1'b1;
                    clear = 1'b1;
                    nxt   = ST_COLLECT;
                end
            end
            default: nxt = ST_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RESET;
        else     state <= nxt;
    end

endmodule

// File: rtl/spk_tx_frame.sv
module spk_tx_frame
    import spk_tx_pkg::*;
(
    input  frame_sel_e         sel,
    input  logic [SR_W-1:0]    acc,
    input  logic [STEP_W-1:0]  step,
    input  logic [MEM_W-1:0]   mem_data,
    input  logic [NRN_W-1:0]   nrn_data,
    output logic [PKT_W-1:0]   frame
);

    always_comb begin
        unique case (sel)
            SEL_MEM:   frame = frame_mem(mem_data);
            SEL_NRN:   frame = frame_nrn(nrn_data);
            SEL_SPIKE: frame = frame_spike(acc, step);
            default:   frame = '0;
        endcase
    end

endmodule

// File: rtl/spk_tx_packer.sv
module spk_tx_packer
    import spk_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run_active,
    input  logic               run_done,
    input  logic [STEP_W-1:0]  step_count,
    input  logic               spk_empty,
    input  logic [NADDR_W-1:0] spk_addr,
    output logic               spk_rd,
    input  logic               mem_empty,
    input  logic [MEM_W-1:0]   mem_data,
    output logic               mem_rd,
    input  logic               nrn_empty,
    input  logic [NRN_W-1:0]   nrn_data,
    output logic               nrn_rd,
    input  logic               tx_full,
    output logic [PKT_W-1:0]   tx_data,
    output logic               tx_wr,
    output logic [1:0]         tx_state
);

    tx_state_e        state;
    frame_sel_e       sel;
    logic             push, clear;
    logic [SR_W-1:0]  acc;
    logic [CNT_W-1:0] count;
    spike_entry_t     entry;

    assign entry    = make_entry(step_count[7:0], spk_addr[15:0]);
    assign tx_state = state;

    spk_tx_ctrl #(.DEPTH(BATCH_N)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .run_active(run_active),
        .run_done  (run_done),
        .spk_empty (spk_empty),
        .mem_empty (mem_empty),
        .nrn_empty (nrn_empty),
        .tx_full   (tx_full),
        .count     (count),
        .state     (state),
        .sel       (sel),
        .spk_rd    (spk_rd),
        .mem_rd    (mem_rd),
        .nrn_rd    (nrn_rd),
        .tx_wr     (tx_wr),
        .push      (push),
        .clear     (clear)
    );

    spk_batch_acc #(.DEPTH(BATCH_N), .EW(ENTRY_W)) batch_i (
        .clk  (clk),
        .rst  (rst),
        .push (push),
        .clear(clear),
        .entry(entry),
        .acc  (acc),
        .count(count)
    );

    spk_tx_frame frame_i (
        .sel     (sel),
        .acc     (acc),
        .step    (step_count),
        .mem_data(mem_data),
        .nrn_data(nrn_data),
        .frame   (tx_data)
    );

endmodule

// File: rtl/spk_tx_packer_chk.sv
module spk_tx_packer_chk (
    input logic         clk,
    input logic         rst,
    input logic         run_active,
    input logic         spk_empty,
    input logic         spk_rd,
    input logic         mem_empty,
    input logic         mem_rd,
    input logic         nrn_empty,
    input logic         nrn_rd,
    input logic         tx_full,
    input logic [511:0] tx_data,
    input logic         tx_wr,
    input logic [1:0]   tx_state
);

    p_no_wr_full_r10: assert property (@(posedge clk) disable iff (rst)
        tx_wr |-> !tx_full);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_state == 2'd3 && tx_full) |=> (tx_state == 2'd3 && $stable(tx_data[511:32])));

    p_spk_rd_r11: assert property (@(posedge clk) disable iff (rst)
        spk_rd |-> !spk_empty);

    p_mem_rd_r11: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !mem_empty);

    p_nrn_rd_r11: assert property (@(posedge clk) disable iff (rst)
        nrn_rd |-> !nrn_empty);

    p_one_rd_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({spk_rd, mem_rd, nrn_rd}));

    p_mem_first_r9: assert property (@(posedge clk) disable iff (rst)
        nrn_rd |-> mem_empty);

    p_spike_tag_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && tx_state == 2'd3) |-> tx_data[511:480] == 32'hEEEE_EEEE);

    p_mem_tag_r7: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (tx_wr && tx_data[511:496] == 16'hBBBB));

    p_nrn_tag_r8: assert property (@(posedge clk) disable iff (rst)
        nrn_rd |-> (tx_wr && tx_data[511:496] == 16'hCCCC));

    p_run_blocks_r12: assert property (@(posedge clk) disable iff (rst)
        (tx_state == 2'd1 && run_active) |-> (!mem_rd && !nrn_rd && !tx_wr));

    p_reset_exit_r1: assert property (@(posedge clk) disable iff (rst)
        (tx_state == 2'd0) |-> (!tx_wr && !spk_rd && !mem_rd && !nrn_rd));

endmodule

bind spk_tx_packer spk_tx_packer_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .run_active(run_active),
    .spk_empty (spk_empty),
    .spk_rd    (spk_rd),
    .mem_empty (mem_empty),
    .mem_rd    (mem_rd),
    .nrn_empty (nrn_empty),
    .nrn_rd    (nrn_rd),
    .tx_full   (tx_full),
    .tx_data   (tx_data),
    .tx_wr     (tx_wr),
    .tx_state  (tx_state)
);

// File: tb/spk_tx_packer_tb_top.sv
`timescale 1ns/1ps
module spk_tx_packer_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         run_active = 1'b0, run_done = 1'b0;
    logic [31:0]  step_count = '0;
    logic         spk_empty = 1'b1, mem_empty = 1'b1, nrn_empty = 1'b1;
    logic [16:0]  spk_addr = '0;
    logic [255:0] mem_data = '0;
    logic [52:0]  nrn_data = '0;
    logic         tx_full = 1'b0;
    logic         spk_rd, mem_rd, nrn_rd, tx_wr;
    logic [511:0] tx_data;
    logic [1:0]   tx_state;

    always #2.5 clk = ~clk;

    spk_tx_packer dut_i (
        .clk(clk), .rst(rst), .run_active(run_active), .run_done(run_done),
        .step_count(step_count), .spk_empty(spk_empty), .spk_addr(spk_addr),
        .spk_rd(spk_rd), .mem_empty(mem_empty), .mem_data(mem_data),
        .mem_rd(mem_rd), .nrn_empty(nrn_empty), .nrn_data(nrn_data),
        .nrn_rd(nrn_rd), .tx_full(tx_full), .tx_data(tx_data),
        .tx_wr(tx_wr), .tx_state(tx_state)
    );

    // stimulus state
    logic [16:0]  spkq[$];
    logic [255:0] memq[$];
    logic [52:0]  nrnq[$];
    logic [511:0] cap[$];
    bit           rst_v = 1'b1, run_v, done_v, full_v;
    logic [31:0]  step_v;
    bit           pop_s, pop_m, pop_n;

    // reference model state
    int           ms = 0;
    logic [31:0]  mbatch[$];

    int checks = 0, errors = 0, cycles = 0;

    function automatic logic [511:0] mk_mem(input logic [255:0] d);
        logic [511:0] p = '0;
        p[511:496] = 16'hBBBB;
        p[255:0]   = d;
        return p;
    endfunction

    function automatic logic [511:0] mk_nrn(input logic [52:0] d);
        logic [511:0] p = '0;
        p[511:496] = 16'hCCCC;
        p[52:0]    = d;
        return p;
    endfunction

    function automatic logic [31:0] mk_ent(input logic [7:0] st, input logic [16:0] a);
        return {st, 1'b1, 7'd0, a[15:0]};
    endfunction

    function automatic logic [511:0] mk_spk(input logic [31:0] ents[$], input logic [31:0] step);
        logic [511:0] p = '0;
        int k = ents.size();
        p[511:480] = 32'hEEEE_EEEE;
        p[31:0]    = step;
        for (int i = 0; i < k; i++) p[32 + 32*(14 - k + i) +: 32] = ents[i];
        return p;
    endfunction

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input logic [511:0] act,
                         input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        bit e_wr, e_s, e_m, e_n;
        int nx;
        logic [511:0] e_data;
        string tag;
        @(negedge clk);
        if (pop_s) void'(spkq.pop_front());
        if (pop_m) void'(memq.pop_front());
        if (pop_n) void'(nrnq.pop_front());
        rst        = rst_v;
        run_active = run_v;
        run_done   = done_v;
        step_count = step_v;
        tx_full    = full_v;
        spk_empty  = (spkq.size() == 0);
        spk_addr   = spk_empty ? '0 : spkq[0];
        mem_empty  = (memq.size() == 0);
        mem_data   = mem_empty ? '0 : memq[0];
        nrn_empty  = (nrnq.size() == 0);
        nrn_data   = nrn_empty ? '0 : nrnq[0];
        #1;
        e_wr = 0; e_s = 0; e_m = 0; e_n = 0; e_data = '0; nx = ms;
        if (rst_v) nx = 0;
        else case (ms)
            0: nx = 1;
            1: if (run_v) nx = 2;
               else if (!full_v) begin
                   if (memq.size() != 0) begin e_wr = 1; e_m = 1; e_data = mk_mem(memq[0]); end
                   else if (nrnq.size() != 0) begin e_wr = 1; e_n = 1; e_data = mk_nrn(nrnq[0]); end
               end
            2: if (mbatch.size() == 14) nx = 3;
               else if (spkq.size() != 0) e_s = 1;
               else if (done_v) nx = (mbatch.size() != 0) ? 3 : 1;
            default: begin
                e_data = mk_spk(mbatch, step_v);
                if (!full_v) begin e_wr = 1; nx = 2; end
            end
        endcase
        tag = rst_v ? "R1" : (ms == 3) ? "R3" : "R9";
        check(tx_state == 2'(ms), rst_v ? "R1" : "R13", 512'(tx_state), 512'(ms));
        check({spk_rd, mem_rd, nrn_rd} == {e_s, e_m, e_n}, "R11",
              512'({spk_rd, mem_rd, nrn_rd}), 512'({e_s, e_m, e_n}));
        check(tx_wr == e_wr, tag, 512'(tx_wr), 512'(e_wr));
        if (e_wr || ms == 3) check(tx_data === e_data, tag, tx_data, e_data);
        if (tx_wr) cap.push_back(tx_data);
        if (e_s) mbatch.push_back(mk_ent(step_v[7:0], spkq[0]));
        if (rst_v || (ms == 3 && e_wr)) mbatch.delete();
        pop_s = e_s; pop_m = e_m; pop_n = e_n;
        ms = nx;
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected under 100000", cycles);
            report();
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wait_cap(input int n);
        for (int i = 0; i < 200 && cap.size() < n; i++) tick();
    endtask

    initial begin
        logic [16:0]  a[14];
        logic [31:0]  ex[$];
        logic [255:0] m0, m1, m2;
        logic [52:0]  n0;
        run_v = 0; done_v = 0; full_v = 0; step_v = 32'd0;

        // reset behaviour (R1)
        ticks(3);
        check(tx_state == 2'd0 && !tx_wr, "R1", 512'(tx_state), 512'd0);
        rst_v = 0;
        ticks(2);
        check(tx_state == 2'd1, "R13", 512'(tx_state), 512'd1);

        // idle forwarding under a full FIFO, then release (R7 R8 R9 R10)
        m0 = {8{32'hA5A5_0001}}; m1 = {8{32'h1234_5678}};
        n0 = {36'h9_8765_4321, 17'h1_ABCD};
        full_v = 1;
        memq.push_back(m0); memq.push_back(m1); nrnq.push_back(n0);
        ticks(4);
        check(cap.size() == 0, "R10", 512'(cap.size()), 512'd0);
        full_v = 0;
        wait_cap(3);
        check(cap.size() == 3, "R9", 512'(cap.size()), 512'd3);
        if (cap.size() == 3) begin
            check(cap[0] === mk_mem(m0), "R7", cap[0], mk_mem(m0));
            check(cap[1] === mk_mem(m1), "R9", cap[1], mk_mem(m1));
            check(cap[2] === mk_nrn(n0), "R8", cap[2], mk_nrn(n0));
        end
        cap.delete();

        // full batch with a stalled send (R2 R3 R4 R10 R12)
        step_v = 32'h0000_0105;
        run_v = 1;
        ticks(2);
        m2 = {4{64'hDEAD_BEEF_0BAD_F00D}};
        memq.push_back(m2);
        full_v = 1;
        for (int i = 0; i < 14; i++) begin
            a[i] = 17'h1_0000 + 17'(i * 17'h111);
            spkq.push_back(a[i]);
        end
        ticks(20);
        check(tx_state == 2'd3 && cap.size() == 0, "R10", 512'(tx_state), 512'd3);
        full_v = 0;
        wait_cap(1);
        ex.delete();
        for (int i = 0; i < 14; i++) ex.push_back(mk_ent(8'h05, a[i]));
        check(cap.size() == 1, "R4", 512'(cap.size()), 512'd1);
        if (cap.size() >= 1) begin
            check(cap[0][63:32] === mk_ent(8'h05, a[0]), "R2", 512'(cap[0][63:32]),
                  512'(mk_ent(8'h05, a[0])));
            check(cap[0] === mk_spk(ex, 32'h0000_0105), "R3", cap[0], mk_spk(ex, 32'h0000_0105));
        end
        tick();
        check(tx_state == 2'd2, "R4", 512'(tx_state), 512'd2);

        // partial batch flushed at run end, held response follows (R5 R12)
        step_v = 32'h0000_0209;
        spkq.push_back(17'h0_0042); spkq.push_back(17'h1_7FFF);
        ticks(4);
        run_v = 0; done_v = 1;
        wait_cap(3);
        ex.delete();
        ex.push_back(mk_ent(8'h09, 17'h0_0042));
        ex.push_back(mk_ent(8'h09, 17'h1_7FFF));
        check(cap.size() == 3, "R12", 512'(cap.size()), 512'd3);
        if (cap.size() == 3) begin
            check(cap[1] === mk_spk(ex, 32'h0000_0209), "R5", cap[1], mk_spk(ex, 32'h0000_0209));
            check(cap[1][415:32] == '0, "R5", 512'(cap[1][415:32]), 512'd0);
            check(cap[2] === mk_mem(m2), "R12", cap[2], mk_mem(m2));
        end
        done_v = 0;
        ticks(2);
        cap.delete();

        // run that ends with nothing pending (R6)
        run_v = 1;
        ticks(3);
        check(tx_state == 2'd2, "R13", 512'(tx_state), 512'd2);
        run_v = 0; done_v = 1;
        ticks(4);
        check(cap.size() == 0, "R6", 512'(cap.size()), 512'd0);
        check(tx_state == 2'd1, "R6", 512'(tx_state), 512'd1);
        done_v = 0;
        ticks(2);

        report();
    end

endmodule